// File: doc/BRIEF.md
# Temperature sensor control and status registers

This block is the register front end of an on-chip temperature sensor. Software reaches it over a simple 32-bit bus with separate read and write strobes and a word address. A mode register powers up the sensor and its converter. A start register requests measurement. Status and result registers report progress and the latest code. Two read-only trim words carry factory calibration values, each with its own validity flag.

Once both mode bits are set, the unit waits a fixed settle time before any measurement begins. A start request made during the settle time is held and takes effect when settling ends. While running, the unit takes a 12-bit code from a stub converter once every conversion period and overwrites the result register. The settle time and the period are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `tsu_regif`

## Requirements
- R1: After reset, the mode, start, result and status registers all read 0.
- R2: The mode register (word 0) stores bits 1:0 of a write and reads other bits as 0. Bit 0 is the sensor enable and bit 1 is the converter enable. Normal mode is the value 2'b11.
- R3: A start request (bit 0 written as 1 to word 1) made during settling is held pending. Status bit 0 (word 4) reads 1 from exactly SETTLE_CYC cycles after the write edge that entered normal mode.
- R4: A start request made after settling is complete sets status bit 0 from the next cycle.
- R5: While running, the result register (word 3) takes sense_code_i in bits 11:0, with bits 31:12 zero. The first capture is PERIOD_CYC cycles after running begins, and a new capture follows every PERIOD_CYC cycles after that.
- R6: Trim word 0 (word 6) and trim word 1 (word 7) each read as the validity flag in bit 31, the 12-bit trim code in bits 11:0, and 0 elsewhere.
- R7: A mode write of any value other than 2'b11 stops conversions on the next cycle and clears the running flag and the start bit (word 1 bit 0). Returning to normal mode needs a fresh full settle time and a new start request.
- R8: Reads of unmapped words (2 and 5) return 0. Writes to the result, status, trim or unmapped words have no effect.
- R9: Writing 0 to start bit 0 stops conversions. A start request written while the mode is not normal is ignored.
- R10: rdata_o loads the addressed word at the clock edge where rd_en_i is high, and holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| sense_code_i | input | 12 | Code presented by the converter stub |
| trim0_code_i | input | 12 | Trim word 0 value |
| trim0_ok_i | input | 1 | Trim word 0 validity flag |
| trim1_code_i | input | 12 | Trim word 1 value |
| trim1_ok_i | input | 1 | Trim word 1 validity flag |

## Verification
The hardest conditions to reach are the exact cycle where a pending start turns into running, and the phase of the free-running capture. The bench holds its bus accesses at one per cycle, so each read has a known offset from the edge that entered normal mode. It checks status and result against the expected settle and first-capture edges on every cycle around those edges. To find the capture phase, it changes the sensed code and polls until the new code appears. It then changes the code again at once and confirms that the old code holds for exactly one period less one cycle.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 12;
  localparam int ADDR_W = 3;
  localparam int FLAG_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE   = 3'd0,
    A_START  = 3'd1,
    A_RESULT = 3'd3,
    A_STATUS = 3'd4,
    A_TRIM0  = 3'd6,
    A_TRIM1  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/tsu_timer.sv
module tsu_timer #(
  parameter int SETTLE_CYC = 60,
  parameter int PERIOD_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic req_i,
  output logic running_o,
  output logic sample_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(PERIOD_CYC);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYC);
  localparam logic [PW-1:0] LAST_V   = PW'(PERIOD_CYC - 1);

  logic [SW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;
  logic          settled;

  assign settled   = normal_i && (cnt_q == SETTLE_V);
  assign running_o = settled && req_i;
  assign sample_o  = running_o && (pcnt_q == LAST_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!normal_i) cnt_q <= '0;
    else if (!settled)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!running_o)        pcnt_q <= '0;
    else if (pcnt_q == LAST_V)  pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end

  // R3
  settle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SETTLE_V);
  // R5
  phase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> pcnt_q == '0);
  // R7
  stop_on_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_i |=> cnt_q == '0 || normal_i);
endmodule

// File: rtl/tsu_adc_stub.sv
module tsu_adc_stub
  import tsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;
  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (sample_i) code_q <= code_i;
  end

  // R5
  capture_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> $past(sample_i));
endmodule

// File: rtl/tsu_regfile.sv
module tsu_regfile
  import tsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CODE_W-1:0] result_i,
  input  logic              running_i,
  input  logic [CODE_W-1:0] trim_code_i [2],
  input  logic [1:0]        trim_ok_i,
  output logic              normal_o,
  output logic              req_o
);
  logic [1:0]        mode_q;
  logic              req_q;
  logic [DATA_W-1:0] rdata_q, rmux;
  logic [DATA_W-1:0] trim_word [2];

  assign normal_o = (mode_q == 2'b11);
  assign req_o    = req_q;
  assign rdata_o  = rdata_q;

  for (genvar g = 0; g < 2; g++) begin : g_trim
    always_comb begin
      trim_word[g]              = '0;
      trim_word[g][CODE_W-1:0]  = trim_code_i[g];
      trim_word[g][FLAG_BIT]    = trim_ok_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      req_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_MODE) begin
        mode_q <= wdata_i[1:0];
        if (wdata_i[1:0] != 2'b11) req_q <= 1'b0;
      end else if (addr_i == A_START) begin
        req_q <= wdata_i[0] & normal_o;
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (addr_i)
      A_MODE:   rmux[1:0]        = mode_q;
      A_START:  rmux[0]          = req_q;
      A_RESULT: rmux[CODE_W-1:0] = result_i;
      A_STATUS: rmux[0]          = running_i;
      A_TRIM0:  rmux             = trim_word[0];
      A_TRIM1:  rmux             = trim_word[1];
      default:  rmux             = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rmux;
  end

  // R7
  mode_drop_clears_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MODE && wdata_i[1:0] != 2'b11) |=> !req_q);
  // R9
  start_needs_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_START && !normal_o) |=> !req_q);
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/tsu_regif.sv
module tsu_regif
  import tsu_pkg::*;
#(
  parameter int CLK_MHZ   = 1,
  parameter int SETTLE_US = 60,
  parameter int PERIOD_US = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CODE_W-1:0] sense_code_i,
  input  logic [CODE_W-1:0] trim0_code_i,
  input  logic              trim0_ok_i,
  input  logic [CODE_W-1:0] trim1_code_i,
  input  logic              trim1_ok_i
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int PERIOD_CYC = CLK_MHZ * PERIOD_US;

  logic              normal, req, running, sample;
  logic [CODE_W-1:0] result;
  logic [CODE_W-1:0] trim_code [2];

  assign trim_code[0] = trim0_code_i;
  assign trim_code[1] = trim1_code_i;

  tsu_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .result_i    (result),
    .running_i   (running),
    .trim_code_i (trim_code),
    .trim_ok_i   ({trim1_ok_i, trim0_ok_i}),
    .normal_o    (normal),
    .req_o       (req)
  );

  tsu_timer #(.SETTLE_CYC(SETTLE_CYC), .PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk_i, .rst_ni,
    .normal_i  (normal),
    .req_i     (req),
    .running_o (running),
    .sample_o  (sample)
  );

  tsu_adc_stub u_adc (
    .clk_i, .rst_ni,
    .sample_i (sample),
    .code_i   (sense_code_i),
    .code_o   (result)
  );

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == 3'd2 || addr_i == 3'd5)) |=> rdata_o == '0);
endmodule

// File: tb/tsu_regif_tb.sv
module tsu_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 60;
  localparam int PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [11:0] sense = '0, t0 = '0, t1 = '0;
  logic        t0ok = 1'b0, t1ok = 1'b0;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsu_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sense_code_i(sense),
    .trim0_code_i(t0), .trim0_ok_i(t0ok),
    .trim1_code_i(t1), .trim1_ok_i(t1ok)
  );

  function automatic logic [31:0] trim_exp(input logic ok, input logic [11:0] c);
    return {ok, 19'b0, c};
  endfunction

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  // tasks are entered at a negedge and take exactly one cycle
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle_walk(input string rq);
    logic [31:0] v;
    // mode write then start write already done; read j sees cnt = 1 + j
    for (int j = SETTLE - 4; j < 0; j++) begin end
    for (int j = 0; j < SETTLE + 2; j++) begin
      rd(3'd4, v);
      if (j >= SETTLE - 4) chk(rq, v, (1 + j >= SETTLE) ? 32'd1 : 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, hold;
    logic [11:0] a, b, c;
    int n;
    void'($urandom(32'd1234));
    t0 = 12'($urandom); t0ok = 1'b1; t1 = 12'($urandom); t1ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd1, v); chk("R1 start", v, 0);
    rd(3'd3, v); chk("R1 result", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    // R6
    rd(3'd6, v); chk("R6 trim0", v, trim_exp(t0ok, t0));
    rd(3'd7, v); chk("R6 trim1", v, trim_exp(t1ok, t1));

    // R2
    wr(3'd0, 32'hFFFF_FFFD); rd(3'd0, v); chk("R2 mode mask", v, 32'd1);
    wr(3'd0, 32'd2); rd(3'd0, v); chk("R2 mode adc bit", v, 32'd2);
    // R9 start ignored while not normal
    wr(3'd1, 32'd1); rd(3'd1, v); chk("R9 start ignored", v, 0);
    rd(3'd4, v); chk("R9 status idle", v, 0);

    // R3 and R5 first capture
    a = 12'($urandom) | 12'h001;
    sense = a;
    wr(3'd0, 32'd3);
    wr(3'd1, 32'd1);
    for (int j = 0; j < SETTLE + PER + 3; j++) begin
      if (j <= SETTLE) begin
        rd(3'd4, v);
        if (j >= SETTLE - 3) chk("R3 settle edge", v, (1 + j >= SETTLE) ? 32'd1 : 32'd0);
      end else begin
        rd(3'd3, v);
        if (j >= SETTLE + PER - 4)
          chk("R5 first capture", v, (1 + j >= SETTLE + PER) ? {20'b0, a} : 32'd0);
      end
    end
    rd(3'd1, v); chk("R3 start held", v, 32'd1);

    // R5 periodic capture, random codes
    c = a;
    for (int k = 0; k < 4; k++) begin
      b = 12'($urandom);
      if (b == c) b = ~c;
      sense = b;
      n = 0;
      do begin rd(3'd3, v); n++; end while (v[11:0] != b && n < 2 * PER);
      chk("R5 capture seen", v, {20'b0, b});
      c = 12'($urandom);
      if (c == b) c = ~b;
      sense = c;
      for (int i = 1; i <= PER; i++) begin
        rd(3'd3, v);
        if (i >= PER - 2) chk("R5 period", v, (i < PER) ? {20'b0, b} : {20'b0, c});
      end
    end

    // R10
    hold = v;
    @(negedge clk); @(negedge clk);
    chk("R10 rdata hold", rdata, hold);

    // R8
    wr(3'd3, 32'h0000_0ABC); wr(3'd4, 32'd0); wr(3'd6, 32'h0); wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R8 result ro", v, {20'b0, c});
    rd(3'd4, v); chk("R8 status ro", v, 32'd1);
    rd(3'd6, v); chk("R8 trim0 ro", v, trim_exp(t0ok, t0));
    rd(3'd7, v); chk("R8 trim1 ro", v, trim_exp(t1ok, t1));
    rd(3'd0, v); chk("R8 mode unchanged", v, 32'd3);
    rd(3'd2, v); chk("R8 unmapped2", v, 0);
    rd(3'd5, v); chk("R8 unmapped5", v, 0);

    // R7
    wr(3'd0, 32'd1);
    rd(3'd4, v); chk("R7 status stop", v, 0);
    rd(3'd1, v); chk("R7 start cleared", v, 0);
    wr(3'd0, 32'd3);
    wr(3'd1, 32'd1);
    settle_walk("R7 fresh settle");

    // R9 stop via start 0, then R4 restart after settle
    wr(3'd1, 32'd0);
    rd(3'd4, v); chk("R9 start0 stops", v, 0);
    wr(3'd1, 32'd1);
    rd(3'd4, v); chk("R4 late start", v, 32'd1);

    // R6 random trims
    for (int k = 0; k < 10; k++) begin
      t0 = 12'($urandom); t1 = 12'($urandom);
      t0ok = 1'($urandom); t1ok = 1'($urandom);
      rd(3'd6, v); chk("R6 trim0 rnd", v, trim_exp(t0ok, t0));
      rd(3'd7, v); chk("R6 trim1 rnd", v, trim_exp(t1ok, t1));
      rd((k % 2) ? 3'd2 : 3'd5, v); chk("R8 unmapped rnd", v, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule